// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one decoded operand-addressing request into the memory address used for a load or a store. It takes the addressing mode, the base register's value and number, the program counter, a displacement and an outer displacement. From these it forms the address and applies automatic pre-decrement or post-increment to the base register. For the memory-indirect form it reads a 32-bit pointer as two 16-bit words through a small read port. It reports illegal requests and read faults, and hands the updated base register value back for the register file to write.

A multi-part operand, such as a 12-byte value moved as several pieces, is handled as consecutive requests. An internal transfer offset walks each later piece forward in memory. A request marked `op_first` starts a new operand and discards the offset left by the previous one. All request fields are sampled in the cycle `start` is high while the block is idle. The result appears with a one-cycle `done` pulse.

Top module: `ea_gen`

## Requirements
- R1: The auto-update step equals `opnd_len`, except that a 1-byte access through register 15 steps by 2.
- R2: Mode 3 (pre-decrement) emits `reg_val - step` with no transfer offset added, writes `reg_val - step` back, and clears the transfer offset.
- R3: Mode 2 (post-increment) emits `reg_val + offset`, writes `reg_val + step` back, and clears the transfer offset.
- R4: After a successful request in any other mode, the transfer offset grows by `opnd_len`. Address-forming modes emit the formed address plus the offset. `op_first` high with `start` treats the offset as 0, and reset sets it to 0.
- R5: With `pc_rel` set the base is `pc + 4`. `pc_rel` is legal only with mode 1, 4 or 5, so post-increment on the PC is illegal.
- R6: Mode 1 forms the base, mode 4 forms base plus signed `disp`, mode 5 forms `disp` alone when `base_supp` is set and base plus `disp` otherwise, and mode 6 forms `disp`. Modes 0 (register direct) and 7 (immediate) emit no address.
- R7: With `mem_indir` set, the block reads the high word at the formed address and then the low word at the formed address plus 2. It emits `{high, low} + outer_disp + offset`.
- R8: A fault on either pointer read raises `err_access` and gives no address, no write-back and no offset change. A fault on the high read skips the low read.
- R9: A store (`is_store` = 1) with mode 7 or with `pc_rel` set is illegal.
- R10: Mode 0 with `opnd_len` above 4, or with a nonzero transfer offset, is illegal.
- R11: `done` is a single-cycle pulse. `addr_valid` is high only with `done`, for modes 1 to 6, when no error is flagged. `wb_en` is high only with `done`, for modes 2 and 3, when no error is flagged, with `wb_idx` equal to `reg_idx`.
- R12: After reset `done`, `addr_valid`, `wb_en` and `rd_req` are low and the transfer offset is 0.
- R13: `opnd_len` other than 1, 2, 4, 8 or 12 is illegal, and so is `mem_indir` with any mode other than 5. An illegal request raises `err_illegal` and changes no offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| op_first | input | 1 | Request begins a new operand |
| is_store | input | 1 | 1 = store, 0 = load |
| mode | input | 3 | Addressing mode 0..7 |
| pc_rel | input | 1 | Use PC + 4 as base |
| mem_indir | input | 1 | Fetch pointer at formed address |
| base_supp | input | 1 | Mode 5 ignores the base |
| opnd_len | input | 4 | Operand length in bytes |
| reg_idx | input | 4 | Base register number |
| reg_val | input | 32 | Base register contents |
| pc | input | 32 | Program counter |
| disp | input | 32 | Displacement or absolute address |
| outer_disp | input | 32 | Outer displacement |
| rd_req | output | 1 | Pointer word read request |
| rd_addr | output | 32 | Pointer word address |
| rd_data | input | 16 | Pointer word read data |
| rd_ack | input | 1 | Read completes this cycle |
| rd_fault | input | 1 | Read faulted |
| addr_valid | output | 1 | `addr` holds an operand address |
| addr | output | 32 | Operand address |
| done | output | 1 | Request finished |
| err_illegal | output | 1 | Illegal request |
| err_access | output | 1 | Pointer read fault |
| wb_en | output | 1 | Write base register back |
| wb_idx | output | 4 | Register to write |
| wb_val | output | 32 | Updated register value |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 8-bit transfer offset and register 15 as the stack pointer. This keeps every addressing mode, every operand length (plus one illegal length), both load and store, and both PC and register bases small enough to sweep completely. The offset carries across the sweep, so offset growth, clearing and the direct-mode second-access rule come up naturally. A separate pass over the memory-indirect path places the pointer so that the high word, the low word or neither faults, across the base-suppress and PC-relative choices.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    AM_REG = 3'd0,
    AM_IND = 3'd1,
    AM_INC = 3'd2,
    AM_DEC = 3'd3,
    AM_OFS = 3'd4,
    AM_IDX = 3'd5,
    AM_ABS = 3'd6,
    AM_IMM = 3'd7
  } amode_e;

  function automatic logic len_legal(input logic [LEN_W-1:0] len);
    return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) ||
           (len == 4'd8) || (len == 4'd12);
  endfunction

  function automatic logic [LEN_W-1:0] step_len(input logic [LEN_W-1:0] len,
                                                input logic is_sp);
    return (is_sp && len == 4'd1) ? 4'd2 : len;
  endfunction
endpackage

// File: rtl/ea_step_calc.sv
module ea_step_calc
  import ea_gen_pkg::*;
#(
  parameter int RIW    = 4,
  parameter int SP_IDX = 15
) (
  input  logic [LEN_W-1:0] len,
  input  logic [RIW-1:0]   ridx,
  output logic             is_sp,
  output logic [LEN_W-1:0] step
);
  always_comb begin
    is_sp = (ridx == RIW'(SP_IDX));
    step  = step_len(len, is_sp);
  end
endmodule

// File: rtl/ea_addr_form.sv
module ea_addr_form
  import ea_gen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int TW     = 8,
  parameter int PC_ADV = 4
) (
  input  amode_e           mode,
  input  logic             pc_rel,
  input  logic             mem_indir,
  input  logic             base_supp,
  input  logic             is_store,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] step,
  input  logic [TW-1:0]    toff,
  input  logic [AW-1:0]    reg_val,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    disp,
  output logic [AW-1:0]    formed,
  output logic             illegal,
  output logic             has_addr,
  output logic             upd_reg,
  output logic [AW-1:0]    new_reg
);
  logic [AW-1:0] base;
  logic [AW-1:0] step_x;
  logic          pc_ok_mode;
  logic          ill_len, ill_store, ill_direct, ill_pc, ill_ind;

  always_comb begin
    base       = pc_rel ? (pc + AW'(PC_ADV)) : reg_val;
    step_x     = AW'(step);
    pc_ok_mode = (mode == AM_IND) || (mode == AM_OFS) || (mode == AM_IDX);

    unique case (mode)
      AM_IND, AM_INC: formed = base;
      AM_DEC:         formed = base - step_x;
      AM_OFS:         formed = base + disp;
      AM_IDX:         formed = base_supp ? disp : (base + disp);
      AM_ABS:         formed = disp;
      default:        formed = '0;
    endcase

    has_addr = (mode != AM_REG) && (mode != AM_IMM);
    upd_reg  = (mode == AM_INC) || (mode == AM_DEC);
    new_reg  = (mode == AM_DEC) ? (reg_val - step_x) : (reg_val + step_x);

    ill_len    = !len_legal(len);
    ill_store  = is_store && ((mode == AM_IMM) || pc_rel);
    ill_direct = (mode == AM_REG) && ((len > LEN_W'(4)) || (toff != '0));
    ill_pc     = pc_rel && !pc_ok_mode;
    ill_ind    = mem_indir && (mode != AM_IDX);
    illegal    = ill_len || ill_store || ill_direct || ill_pc || ill_ind;
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch #(
  parameter int AW = 32,
  localparam int HW = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] ia,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [HW-1:0] rd_data,
  input  logic          rd_ack,
  input  logic          rd_fault,
  output logic          fin,
  output logic          fault,
  output logic [AW-1:0] ptr
);
  typedef enum logic [1:0] {F_IDLE, F_HI, F_LO} fstate_e;
  fstate_e       st;
  logic [AW-1:0] ia_q;
  logic [HW-1:0] hi_q;

  logic hi_take, hi_bad, lo_take;
  assign hi_take = (st == F_HI) && rd_ack;
  assign hi_bad  = hi_take && rd_fault;
  assign lo_take = (st == F_LO) && rd_ack;

  assign rd_req  = (st != F_IDLE);
  assign rd_addr = (st == F_LO) ? (ia_q + AW'(2)) : ia_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      ia_q  <= '0;
      hi_q  <= '0;
      fin   <= 1'b0;
      fault <= 1'b0;
      ptr   <= '0;
    end else begin
      fin <= hi_bad || lo_take;
      if (hi_bad || lo_take) fault <= hi_bad || rd_fault;
      if (lo_take) ptr <= {hi_q, rd_data};
      unique case (st)
        F_IDLE: if (go) begin ia_q <= ia; st <= F_HI; end
        F_HI: if (rd_ack) begin
          hi_q <= rd_data;
          st   <= rd_fault ? F_IDLE : F_LO;
        end
        F_LO: if (rd_ack) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  a_r8_hi_fault_skips_lo: assert property (@(posedge clk) disable iff (!rst_n)
    hi_bad |=> !rd_req);
  a_r7_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_take && !rd_fault) |=> (rd_req && rd_addr == $past(rd_addr) + AW'(2)));
  a_r7_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIW    = 4,
  parameter int TW     = 8,
  parameter int SP_IDX = 15,
  parameter int PC_ADV = 4,
  localparam int HW = AW / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_first,
  input  logic             is_store,
  input  logic [2:0]       mode,
  input  logic             pc_rel,
  input  logic             mem_indir,
  input  logic             base_supp,
  input  logic [LEN_W-1:0] opnd_len,
  input  logic [RIW-1:0]   reg_idx,
  input  logic [AW-1:0]    reg_val,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    disp,
  input  logic [AW-1:0]    outer_disp,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic [HW-1:0]    rd_data,
  input  logic             rd_ack,
  input  logic             rd_fault,
  output logic             addr_valid,
  output logic [AW-1:0]    addr,
  output logic             done,
  output logic             err_illegal,
  output logic             err_access,
  output logic             wb_en,
  output logic [RIW-1:0]   wb_idx,
  output logic [AW-1:0]    wb_val
);
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_WAIT, S_FIN} state_e;
  state_e st;

  amode_e           mode_q;
  logic             store_q, pcr_q, mi_q, bs_q;
  logic [LEN_W-1:0] len_q;
  logic [RIW-1:0]   ridx_q;
  logic [AW-1:0]    reg_q, pc_q, disp_q, outer_q;
  logic [TW-1:0]    tdisp_q;
  logic [AW-1:0]    addr_q, newreg_q;
  logic             ill_q, acc_q, has_q, upd_q;

  logic [LEN_W-1:0] step;
  logic             is_sp;
  logic [AW-1:0]    formed, new_reg;
  logic             illegal, has_addr, upd_reg;
  logic [TW-1:0]    toff_use;
  logic             fetch_go, f_fin, f_fault;
  logic [AW-1:0]    f_ptr;
  logic             req_ok, toff_clear;

  ea_step_calc #(.RIW(RIW), .SP_IDX(SP_IDX)) u_step (
    .len(len_q), .ridx(ridx_q), .is_sp(is_sp), .step(step)
  );

  ea_addr_form #(.AW(AW), .TW(TW), .PC_ADV(PC_ADV)) u_form (
    .mode(mode_q), .pc_rel(pcr_q), .mem_indir(mi_q), .base_supp(bs_q),
    .is_store(store_q), .len(len_q), .step(step), .toff(tdisp_q),
    .reg_val(reg_q), .pc(pc_q), .disp(disp_q), .formed(formed),
    .illegal(illegal), .has_addr(has_addr), .upd_reg(upd_reg),
    .new_reg(new_reg)
  );

  assign fetch_go = (st == S_CALC) && !illegal && mi_q;

  ea_ptr_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .ia(formed),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ack(rd_ack), .rd_fault(rd_fault), .fin(f_fin), .fault(f_fault),
    .ptr(f_ptr)
  );

  assign toff_use   = (mode_q == AM_DEC) ? '0 : tdisp_q;
  assign req_ok     = !ill_q && !acc_q;
  assign toff_clear = (mode_q == AM_INC) || (mode_q == AM_DEC);

  assign done        = (st == S_FIN);
  assign err_illegal = done && ill_q;
  assign err_access  = done && acc_q;
  assign addr_valid  = done && has_q && req_ok;
  assign addr        = addr_q;
  assign wb_en       = done && upd_q && req_ok;
  assign wb_idx      = ridx_q;
  assign wb_val      = newreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= AM_REG;
      store_q  <= 1'b0;
      pcr_q    <= 1'b0;
      mi_q     <= 1'b0;
      bs_q     <= 1'b0;
      len_q    <= '0;
      ridx_q   <= '0;
      reg_q    <= '0;
      pc_q     <= '0;
      disp_q   <= '0;
      outer_q  <= '0;
      tdisp_q  <= '0;
      addr_q   <= '0;
      newreg_q <= '0;
      ill_q    <= 1'b0;
      acc_q    <= 1'b0;
      has_q    <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          mode_q  <= amode_e'(mode);
          store_q <= is_store;
          pcr_q   <= pc_rel;
          mi_q    <= mem_indir;
          bs_q    <= base_supp;
          len_q   <= opnd_len;
          ridx_q  <= reg_idx;
          reg_q   <= reg_val;
          pc_q    <= pc;
          disp_q  <= disp;
          outer_q <= outer_disp;
          if (op_first) tdisp_q <= '0;
          acc_q   <= 1'b0;
          st      <= S_CALC;
        end
        S_CALC: begin
          ill_q    <= illegal;
          has_q    <= has_addr;
          upd_q    <= upd_reg;
          newreg_q <= new_reg;
          addr_q   <= formed + AW'(toff_use);
          st       <= (!illegal && mi_q) ? S_WAIT : S_FIN;
        end
        S_WAIT: if (f_fin) begin
          acc_q  <= f_fault;
          addr_q <= f_ptr + outer_q + AW'(toff_use);
          st     <= S_FIN;
        end
        S_FIN: begin
          if (req_ok)
            tdisp_q <= toff_clear ? '0 : (tdisp_q + TW'(len_q));
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (done && !err_illegal && !err_access));
  a_r11_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && !err_illegal && !err_access));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_fault_blocks_result: assert property (@(posedge clk) disable iff (!rst_n)
    err_access |-> (!wb_en && !addr_valid));
  a_r1_sp_keeps_even: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_idx == RIW'(SP_IDX)) |-> (wb_val[0] == reg_q[0]));
  a_r2_dec_clears_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && mode_q == AM_DEC) |=> (tdisp_q == '0));
  a_r9_store_imm_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && store_q && mode_q == AM_IMM) |-> err_illegal);
  a_r12_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !rd_req);
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_first = 1'b0, is_store = 1'b0;
  logic [2:0]  mode = '0;
  logic        pc_rel = 1'b0, mem_indir = 1'b0, base_supp = 1'b0;
  logic [3:0]  opnd_len = 4'd1;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_val = '0, pc = '0, disp = '0, outer_disp = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic        rd_ack = 1'b0, rd_fault = 1'b0;
  logic        addr_valid, done, err_illegal, err_access, wb_en;
  logic [31:0] addr, wb_val;
  logic [3:0]  wb_idx;

  int total = 0;
  int bad = 0;
  int reads = 0;
  logic [7:0] tq_m = '0;

  always #2 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_first(op_first),
    .is_store(is_store), .mode(mode), .pc_rel(pc_rel), .mem_indir(mem_indir),
    .base_supp(base_supp), .opnd_len(opnd_len), .reg_idx(reg_idx),
    .reg_val(reg_val), .pc(pc), .disp(disp), .outer_disp(outer_disp),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack),
    .rd_fault(rd_fault), .addr_valid(addr_valid), .addr(addr), .done(done),
    .err_illegal(err_illegal), .err_access(err_access), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  function automatic logic mem_bad(input logic [31:0] a);
    return a[31:28] == 4'hF;
  endfunction

  always @(negedge clk) begin
    rd_ack   <= rd_req;
    rd_data  <= mem_word(rd_addr);
    rd_fault <= rd_req && mem_bad(rd_addr);
    if (rd_req) reads <= reads + 1;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic xact(input logic [2:0] m, input logic [3:0] len,
                      input logic [3:0] ri, input logic st, input logic pcr,
                      input logic mi, input logic bs, input logic opf,
                      input logic [31:0] rv, input logic [31:0] pcv,
                      input logic [31:0] dv, input logic [31:0] ov,
                      input string tag);
    logic [7:0]  tq_e;
    logic        len_ok, ill, acc, fh, fl, exp_valid, exp_wb;
    logic [31:0] stp, b, form, ptr, exp_addr, exp_wbv;
    int          exp_reads, waited;
    tq_e   = opf ? 8'd0 : tq_m;
    len_ok = (len == 1) || (len == 2) || (len == 4) || (len == 8) || (len == 12);
    ill = !len_ok || (st && (m == 7 || pcr)) ||
          (m == 0 && (len > 4 || tq_e != 0)) ||
          (pcr && !(m == 1 || m == 4 || m == 5)) || (mi && m != 5);
    stp = (len == 1 && ri == 15) ? 32'd2 : {28'd0, len};
    b   = pcr ? pcv + 32'd4 : rv;
    case (m)
      3'd1, 3'd2: form = b;
      3'd3:       form = b - stp;
      3'd4:       form = b + dv;
      3'd5:       form = bs ? dv : b + dv;
      3'd6:       form = dv;
      default:    form = 32'd0;
    endcase
    fh = 1'b0; fl = 1'b0; exp_reads = 0;
    ptr = {mem_word(form), mem_word(form + 32'd2)};
    if (mi && !ill) begin
      fh = mem_bad(form);
      fl = !fh && mem_bad(form + 32'd2);
      exp_reads = fh ? 1 : 2;
    end
    acc       = fh || fl;
    exp_valid = !ill && !acc && (m >= 1 && m <= 6);
    exp_wb    = !ill && !acc && (m == 2 || m == 3);
    exp_addr  = mi ? ptr + ov + {24'd0, tq_e} : form + ((m == 3) ? 32'd0 : {24'd0, tq_e});
    exp_wbv   = (m == 3) ? rv - stp : rv + stp;

    @(negedge clk);
    reads = 0;
    start = 1'b1; op_first = opf; is_store = st; mode = m; pc_rel = pcr;
    mem_indir = mi; base_supp = bs; opnd_len = len; reg_idx = ri;
    reg_val = rv; pc = pcv; disp = dv; outer_disp = ov;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk("R11", "done seen", {31'd0, done}, 32'd1);
    chk(ill ? "R9/R10/R13" : tag, "err_illegal", {31'd0, err_illegal}, {31'd0, ill});
    chk("R8", "err_access", {31'd0, err_access}, {31'd0, acc});
    chk("R11", "addr_valid", {31'd0, addr_valid}, {31'd0, exp_valid});
    chk("R11", "wb_en", {31'd0, wb_en}, {31'd0, exp_wb});
    if (exp_valid) chk(tag, "addr", addr, exp_addr);
    if (exp_wb) begin
      chk(tag, "wb_val", wb_val, exp_wbv);
      chk("R11", "wb_idx", {28'd0, wb_idx}, {28'd0, ri});
    end
    if (mi) chk("R8", "pointer reads", reads, exp_reads);
    @(negedge clk);
    chk("R11", "done pulse ends", {31'd0, done}, 32'd0);
    tq_m = tq_e;
    if (!ill && !acc) tq_m = (m == 2 || m == 3) ? 8'd0 : tq_e + {4'd0, len};
  endtask

  function automatic logic [3:0] len_at(input int i);
    case (i)
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd4;
      3: return 4'd8;
      4: return 4'd12;
      default: return 4'd3;
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    string tg;
    repeat (3) @(negedge clk);
    chk("R12", "done after reset", {31'd0, done}, 32'd0);
    chk("R12", "addr_valid after reset", {31'd0, addr_valid}, 32'd0);
    chk("R12", "wb_en after reset", {31'd0, wb_en}, 32'd0);
    chk("R12", "rd_req after reset", {31'd0, rd_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: offset is zero after reset even without op_first
    xact(3'd6, 4'd4, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
         32'h0, 32'h0, 32'h0000_4000, 32'h0, "R12");
    // R10: second direct piece after a nonzero offset is illegal
    xact(3'd0, 4'd4, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
         32'h1, 32'h0, 32'h0, 32'h0, "R10");
    xact(3'd0, 4'd4, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
         32'h1, 32'h0, 32'h0, 32'h0, "R10");
    // R1: byte through stack pointer steps by 2, through other register by 1
    xact(3'd3, 4'd1, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
         32'h0000_2000, 32'h0, 32'h0, 32'h0, "R1");
    xact(3'd2, 4'd1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
         32'h0000_2000, 32'h0, 32'h0, 32'h0, "R1");
    xact(3'd2, 4'd1, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
         32'h0000_2001, 32'h0, 32'h0, 32'h0, "R1");
    // R4: multi-part absolute operand steps through memory
    xact(3'd6, 4'd4, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
         32'h0, 32'h0, 32'h0000_8000, 32'h0, "R4");
    xact(3'd6, 4'd4, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
         32'h0, 32'h0, 32'h0000_8000, 32'h0, "R4");
    xact(3'd6, 4'd4, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
         32'h0, 32'h0, 32'h0000_8000, 32'h0, "R4");

    // Near-exhaustive sweep over mode, length, register, direction, base
    n = 0;
    for (int m = 0; m < 8; m++)
      for (int li = 0; li < 6; li++)
        for (int sp = 0; sp < 2; sp++)
          for (int st = 0; st < 2; st++)
            for (int pr = 0; pr < 2; pr++) begin
              n++;
              case (m)
                2: tg = "R3";
                3: tg = "R2";
                4, 5, 6: tg = pr ? "R5" : "R6";
                default: tg = pr ? "R5" : "R4";
              endcase
              xact(3'(m), len_at(li), sp ? 4'd15 : 4'd9, st[0], pr[0], 1'b0,
                   n[0], (n % 3) != 0,
                   32'h1000_0000 + 32'(n * 52), 32'h0040_0000 + 32'(n * 6),
                   n[1] ? -32'(n * 3) : 32'(n * 17), 32'h0, tg);
            end

    // Memory-indirect sweep: no fault, high-word fault, low-word fault
    for (int f = 0; f < 3; f++)
      for (int bs = 0; bs < 2; bs++)
        for (int pr = 0; pr < 2; pr++)
          for (int st = 0; st < 2; st++) begin
            logic [31:0] tgt;
            tgt = (f == 0) ? 32'h0012_3450 : (f == 1) ? 32'hF000_0010 : 32'hEFFF_FFFE;
            // formed = bs ? disp : base + disp; base is pc+4 or reg_val
            xact(3'd5, 4'd4, 4'd10, st[0], pr[0], 1'b1, bs[0], st[0],
                 32'h0000_1000, 32'h0000_0ffc,
                 bs ? tgt : tgt - (pr ? 32'h0000_1000 : 32'h0000_1000),
                 32'h0000_0040, f == 0 ? "R7" : "R8");
          end
    // R13: memory-indirect outside mode 5 is illegal
    xact(3'd4, 4'd4, 4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
         32'h100, 32'h0, 32'h4, 32'h0, "R13");

    summary();
    $finish;
  end
endmodule